// File: doc/BRIEF.md
# Parity-Guarded Scratchpad with Replica Repair

This block is a single-port data scratchpad. Every stored word carries even parity, and the parity is checked on every read. A plain even-parity code detects any odd number of flipped bits but cannot locate them. So the block does not decode anything to repair a word. When a check fails, a small sequencer fetches a good copy of the word from outside and writes it back. It then returns the repaired word to the requester.

Each line keeps a dirty flag. Every host write sets the flag, and an external clean command clears it. A dirty line has its only good copy in the cache, so the repair copy is read from the cache port. A clean line matches lower-level memory, so the copy is read from the memory port. Every write to the array, host or corrective, is also sent out on a replica-write port. The cache copy therefore always follows the scratchpad. While recovery is running, `recovering` is high and the corrective write is sent out as write-through traffic. A bit-flip port lets a test corrupt stored data without touching parity or dirty state.

Top module: `pscr_top`

## Requirements
- R1: After synchronous reset every word holds zero with matching parity and every line is clean. `rsp_valid`, `par_err`, `busy` and `recovering` are low.
- R2: A write (`req_en`=1, `req_write`=1, `busy`=0) stores `req_wdata` with freshly generated even parity and sets the line's dirty flag. In the same cycle it presents address and data on the `cache_wr_*` port.
- R3: A read (`req_en`=1, `req_write`=0, `busy`=0) of a word whose parity matches returns the word on `rsp_data` with `rsp_valid` high for one cycle. This happens after the second rising edge following acceptance, with no error flag.
- R4: Parity group g covers data bits [g*DATA_W/GROUPS +: DATA_W/GROUPS]. Its bit is the XOR of those bits. An odd number of flips in any group raises `par_err` for exactly one cycle after the second rising edge. `busy` stays high until the repaired word is returned.
- R5: After a mismatch, exactly one replica read is raised and held until its valid arrives. `cache_rd_req` is used when the line is dirty and `mem_rd_req` when it is clean. `rep_rd_addr` gives the word address.
- R6: On the edge where the selected valid is high, the response is captured. On the next edge it is written into the array with fresh parity and returned with `rsp_valid`. A later read of that word shows no error.
- R7: `recovering` is high from the fetch until the corrective write. The corrective write appears on the `cache_wr_*` port.
- R8: A request with `req_en` high while `busy` is high is ignored. It stores nothing, emits no replica write and produces no response.
- R9: `clean_en` clears the dirty flag of `clean_addr`, so the next repair of that line uses the memory port. A later host write makes the line dirty again.
- R10: An even number of flips within every group goes undetected. The read returns the corrupted word with no flag.
- R11: `inj_en` XORs `inj_mask` into the stored data of `inj_addr`. Parity and dirty flag are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_data | output | DATA_W | Read data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| par_err | output | 1 | Parity mismatch seen, one-cycle pulse |
| busy | output | 1 | Request in flight, new requests ignored |
| recovering | output | 1 | Replica fetch or corrective write in progress |
| clean_en | input | 1 | Clear a line's dirty flag |
| clean_addr | input | ADDR_W | Line to mark clean |
| inj_en | input | 1 | Flip stored data bits |
| inj_addr | input | ADDR_W | Word to corrupt |
| inj_mask | input | DATA_W | Bits to flip |
| cache_rd_req | output | 1 | Replica read request to cache |
| mem_rd_req | output | 1 | Replica read request to lower memory |
| rep_rd_addr | output | ADDR_W | Replica read address |
| cache_rd_valid | input | 1 | Cache replica data valid |
| cache_rd_data | input | DATA_W | Cache replica data |
| mem_rd_valid | input | 1 | Lower-memory data valid |
| mem_rd_data | input | DATA_W | Lower-memory data |
| cache_wr_en | output | 1 | Replica write strobe |
| cache_wr_addr | output | ADDR_W | Replica write address |
| cache_wr_data | output | DATA_W | Replica write data |

## Verification
The hardest case to reach is a request that arrives while a repair is still waiting on a slow replica response. The bench lengthens the model's response latency and corrupts a word. It starts the read and then drives a write and a read while `busy` is high. It then confirms that neither left a trace in the array, on the replica-write port or in the response stream. The change from clean to dirty source is reached by corrupting a line after a clean command, and then again after a rewrite. Even-weight flips are stacked on one word and then topped up to odd weight. This shows that the undetected corruption is still repaired from the right source.

// File: rtl/pscr_pkg.sv
package pscr_pkg;

    parameter int unsigned DEF_DATA_W = 32;
    parameter int unsigned DEF_ADDR_W = 4;
    parameter int unsigned DEF_GROUPS = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_WBACK
    } rec_state_e;

    typedef enum logic {
        SRC_LOWER = 1'b0,
        SRC_CACHE = 1'b1
    } rep_src_e;

endpackage

// File: rtl/pscr_parity_gen.sv
module pscr_parity_gen #(
    parameter int DATA_W = 32,
    parameter int GROUPS = 1
) (
    input  logic [DATA_W-1:0] d,
    output logic [GROUPS-1:0] p
);
    localparam int GW = DATA_W / GROUPS;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign p[g] = ^d[g*GW +: GW];
    end
endmodule

// File: rtl/pscr_store.sv
module pscr_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 16,
    parameter int GROUPS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [GROUPS-1:0] wpar,
    input  logic              wset_dirty,
    input  logic              clean_en,
    input  logic [ADDR_W-1:0] clean_addr,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [DATA_W-1:0] inj_mask,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [GROUPS-1:0] rpar,
    output logic              rdirty
);
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [GROUPS-1:0] par_q  [DEPTH];
    logic [DEPTH-1:0]  dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                data_q[i] <= '0;
                par_q[i]  <= '0;
            end
            dirty_q <= '0;
        end else begin
            if (inj_en)
                data_q[inj_addr] <= data_q[inj_addr] ^ inj_mask;
            if (clean_en)
                dirty_q[clean_addr] <= 1'b0;
            if (we) begin
                data_q[waddr] <= wdata;
                par_q[waddr]  <= wpar;
                if (wset_dirty)
                    dirty_q[waddr] <= 1'b1;
            end
        end
    end

    assign rdata  = data_q[raddr];
    assign rpar   = par_q[raddr];
    assign rdirty = dirty_q[raddr];

    // R2
    dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
        (we && wset_dirty) |=> dirty_q[$past(waddr)]);

    // R9
    dirty_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clean_en && !(we && wset_dirty)) |=> !dirty_q[$past(clean_addr)]);
endmodule

// File: rtl/pscr_recover_fsm.sv
module pscr_recover_fsm
    import pscr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int GROUPS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic [GROUPS-1:0] arr_par,
    input  logic              arr_dirty,
    output logic              busy,
    output logic              recovering,
    output logic              err_pulse,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              cache_rd_req,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] rep_addr,
    input  logic              cache_rd_valid,
    input  logic [DATA_W-1:0] cache_rd_data,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    rec_state_e        st_q;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [GROUPS-1:0] cap_par;
    rep_src_e          cap_src;
    logic [GROUPS-1:0] calc_par;
    logic              got;
    logic [DATA_W-1:0] resp;

    pscr_parity_gen #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_chk (
        .d(cap_data),
        .p(calc_par)
    );

    assign got  = (cap_src == SRC_CACHE) ? cache_rd_valid : mem_rd_valid;
    assign resp = (cap_src == SRC_CACHE) ? cache_rd_data  : mem_rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cap_addr  <= '0;
            cap_data  <= '0;
            cap_par   <= '0;
            cap_src   <= SRC_LOWER;
            err_pulse <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            err_pulse <= 1'b0;
            out_valid <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (rd_go) begin
                    cap_addr <= rd_addr;
                    cap_data <= arr_data;
                    cap_par  <= arr_par;
                    cap_src  <= arr_dirty ? SRC_CACHE : SRC_LOWER;
                    st_q     <= ST_CHECK;
                end
                ST_CHECK: if (calc_par == cap_par) begin
                    out_data  <= cap_data;
                    out_valid <= 1'b1;
                    st_q      <= ST_IDLE;
                end else begin
                    err_pulse <= 1'b1;
                    st_q      <= ST_FETCH;
                end
                ST_FETCH: if (got) begin
                    cap_data <= resp;
                    st_q     <= ST_WBACK;
                end
                ST_WBACK: begin
                    out_data  <= cap_data;
                    out_valid <= 1'b1;
                    st_q      <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (st_q != ST_IDLE);
    assign recovering   = (st_q == ST_FETCH) || (st_q == ST_WBACK);
    assign cache_rd_req = (st_q == ST_FETCH) && (cap_src == SRC_CACHE);
    assign mem_rd_req   = (st_q == ST_FETCH) && (cap_src == SRC_LOWER);
    assign rep_addr     = cap_addr;
    assign wb_en        = (st_q == ST_WBACK);
    assign wb_addr      = cap_addr;
    assign wb_data      = cap_data;

    // R4
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    // R5
    single_source_chk: assert property (@(posedge clk) disable iff (rst)
        !(cache_rd_req && mem_rd_req));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((cache_rd_req && !cache_rd_valid) || (mem_rd_req && !mem_rd_valid))
        |=> (cache_rd_req || mem_rd_req));

    // R6
    wback_follows_chk: assert property (@(posedge clk) disable iff (rst)
        ((cache_rd_req && cache_rd_valid) || (mem_rd_req && mem_rd_valid)) |=> wb_en);

    // R4
    busy_after_err_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> busy);
endmodule

// File: rtl/pscr_top.sv
module pscr_top
    import pscr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DEPTH  = 1 << ADDR_W,
    parameter int GROUPS = DEF_GROUPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_en,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_valid,
    output logic              par_err,
    output logic              busy,
    output logic              recovering,
    input  logic              clean_en,
    input  logic [ADDR_W-1:0] clean_addr,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [DATA_W-1:0] inj_mask,
    output logic              cache_rd_req,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] rep_rd_addr,
    input  logic              cache_rd_valid,
    input  logic [DATA_W-1:0] cache_rd_data,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              cache_wr_en,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [DATA_W-1:0] cache_wr_data
);
    logic              host_we, rd_go;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [DATA_W-1:0] arr_wdata;
    logic [GROUPS-1:0] arr_wpar;
    logic [DATA_W-1:0] arr_rdata;
    logic [GROUPS-1:0] arr_rpar;
    logic              arr_rdirty;
    logic              wb_en;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;

    assign host_we   = req_en &&  req_write && !busy;
    assign rd_go     = req_en && !req_write && !busy;
    assign arr_we    = host_we || wb_en;
    assign arr_waddr = wb_en ? wb_addr : req_addr;
    assign arr_wdata = wb_en ? wb_data : req_wdata;

    pscr_parity_gen #(.DATA_W(DATA_W), .GROUPS(GROUPS)) u_enc (
        .d(arr_wdata),
        .p(arr_wpar)
    );

    pscr_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .GROUPS(GROUPS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (arr_we),
        .waddr      (arr_waddr),
        .wdata      (arr_wdata),
        .wpar       (arr_wpar),
        .wset_dirty (host_we),
        .clean_en   (clean_en),
        .clean_addr (clean_addr),
        .inj_en     (inj_en),
        .inj_addr   (inj_addr),
        .inj_mask   (inj_mask),
        .raddr      (req_addr),
        .rdata      (arr_rdata),
        .rpar       (arr_rpar),
        .rdirty     (arr_rdirty)
    );

    pscr_recover_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .GROUPS(GROUPS)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .rd_go          (rd_go),
        .rd_addr        (req_addr),
        .arr_data       (arr_rdata),
        .arr_par        (arr_rpar),
        .arr_dirty      (arr_rdirty),
        .busy           (busy),
        .recovering     (recovering),
        .err_pulse      (par_err),
        .out_valid      (rsp_valid),
        .out_data       (rsp_data),
        .cache_rd_req   (cache_rd_req),
        .mem_rd_req     (mem_rd_req),
        .rep_addr       (rep_rd_addr),
        .cache_rd_valid (cache_rd_valid),
        .cache_rd_data  (cache_rd_data),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_data    (mem_rd_data),
        .wb_en          (wb_en),
        .wb_addr        (wb_addr),
        .wb_data        (wb_data)
    );

    assign cache_wr_en   = arr_we;
    assign cache_wr_addr = arr_waddr;
    assign cache_wr_data = arr_wdata;

    // R8
    no_host_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cache_wr_en && busy) |-> recovering);

    // R7
    wthrough_in_recovery_chk: assert property (@(posedge clk) disable iff (rst)
        (recovering && !cache_rd_req && !mem_rd_req) |-> cache_wr_en);

    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);
endmodule

// File: tb/sim_pscr_top.sv
`timescale 1ns/1ps
module sim_pscr_top;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_en = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_data;
    logic rsp_valid, par_err, busy, recovering;
    logic clean_en = 0;
    logic [AW-1:0] clean_addr = '0;
    logic inj_en = 0;
    logic [AW-1:0] inj_addr = '0;
    logic [DW-1:0] inj_mask = '0;
    logic cache_rd_req, mem_rd_req;
    logic [AW-1:0] rep_rd_addr;
    logic cache_rd_valid = 0, mem_rd_valid = 0;
    logic [DW-1:0] cache_rd_data = '0, mem_rd_data = '0;
    logic cache_wr_en;
    logic [AW-1:0] cache_wr_addr;
    logic [DW-1:0] cache_wr_data;

    always #2.5 clk = ~clk;

    pscr_top u0 (
        .clk(clk), .rst(rst), .req_en(req_en), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_data(rsp_data),
        .rsp_valid(rsp_valid), .par_err(par_err), .busy(busy),
        .recovering(recovering), .clean_en(clean_en), .clean_addr(clean_addr),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
        .cache_rd_req(cache_rd_req), .mem_rd_req(mem_rd_req),
        .rep_rd_addr(rep_rd_addr), .cache_rd_valid(cache_rd_valid),
        .cache_rd_data(cache_rd_data), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .cache_wr_en(cache_wr_en),
        .cache_wr_addr(cache_wr_addr), .cache_wr_data(cache_wr_data)
    );

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        bit            e;
        int            src;   // 0 none, 1 cache, 2 lower memory
    } exp_t;

    exp_t sbq[$];
    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] shadow [DEPTH];
    logic [DW-1:0] flips  [DEPTH];
    logic [DW-1:0] cache_m[DEPTH];
    logic [DW-1:0] low_m  [DEPTH];
    bit            dirty_m[DEPTH];
    int resp_lat = 0;
    int wait_cnt = 0;
    int wt_cnt = 0;
    int src_seen = 0;
    bit err_seen = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // replica models: cache and lower memory
    initial forever begin
        @(negedge clk); #1;
        if (cache_rd_req && mem_rd_req)
            check(0, "R5 both replica requests", 2, 1);
        if (cache_rd_req || mem_rd_req) begin
            src_seen = cache_rd_req ? 1 : 2;
            if (wait_cnt >= resp_lat) begin
                cache_rd_valid = cache_rd_req;
                mem_rd_valid   = mem_rd_req;
                cache_rd_data  = cache_m[rep_rd_addr];
                mem_rd_data    = low_m[rep_rd_addr];
            end
            wait_cnt++;
        end else begin
            cache_rd_valid = 0;
            mem_rd_valid   = 0;
            wait_cnt       = 0;
        end
    end

    // monitor and scoreboard
    initial forever begin
        @(negedge clk); #1;
        if (!rst) begin
            if (cache_wr_en) begin
                cache_m[cache_wr_addr] = cache_wr_data;
                if (recovering) wt_cnt++;
            end
            if (par_err) err_seen = 1;
            if (rsp_valid) begin
                if (sbq.size() == 0) begin
                    check(0, "R8 response with nothing expected", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(rsp_data == e.d, e.e ? "R6 repaired data" : "R3 read data",
                          rsp_data, e.d);
                    check(err_seen == e.e, e.e ? "R4 error flag" : "R10 no error flag",
                          err_seen, e.e);
                    check(src_seen == e.src, "R5 replica source", src_seen, e.src);
                end
                err_seen = 0;
                src_seen = 0;
            end
        end
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_en = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_en = 0; req_write = 0;
        shadow[a] = d; flips[a] = '0; dirty_m[a] = 1;
        wait_idle();
    endtask

    task automatic rd_start(input logic [AW-1:0] a);
        exp_t e;
        e.a = a;
        e.e = ^flips[a];
        if (e.e) begin
            e.d = shadow[a];
            e.src = dirty_m[a] ? 1 : 2;
            flips[a] = '0;
        end else begin
            e.d = shadow[a] ^ flips[a];
            e.src = 0;
        end
        sbq.push_back(e);
        @(negedge clk);
        req_en = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_en = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        rd_start(a);
        wait_idle();
    endtask

    task automatic inj(input logic [AW-1:0] a, input logic [DW-1:0] m);
        @(negedge clk);
        inj_en = 1; inj_addr = a; inj_mask = m;
        @(negedge clk);
        inj_en = 0;
        flips[a] ^= m;
    endtask

    task automatic cln(input logic [AW-1:0] a);
        @(negedge clk);
        clean_en = 1; clean_addr = a;
        @(negedge clk);
        clean_en = 0;
        dirty_m[a] = 0;
        low_m[a] = shadow[a];
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int wt0;
        for (int i = 0; i < DEPTH; i++) begin
            shadow[i] = '0; flips[i] = '0; cache_m[i] = '0; low_m[i] = '0; dirty_m[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        // R1 reset state
        check(!busy && !rsp_valid && !par_err && !recovering, "R1 idle outputs",
              {busy, rsp_valid, par_err, recovering}, 0);
        rd(0);
        rd(15);

        // R2 writes, R3 clean reads
        wr(1, 32'h1234_5678);
        wr(2, 32'hCAFE_0001);
        wr(3, 32'h0F0F_F0F0);
        wr(7, 32'h7777_0007);
        wr(9, 32'h9999_AAAA);
        check(cache_m[3] == 32'h0F0F_F0F0, "R2 replica write", cache_m[3], 32'h0F0F_F0F0);
        rd(1); rd(2); rd(3); rd(7); rd(9);

        // R4 R5 R6 R7 single flip on dirty line
        wt0 = wt_cnt;
        inj(3, 32'h0000_0020);
        rd(3);
        check(wt_cnt == wt0 + 1, "R7 write-through during recovery", wt_cnt, wt0 + 1);
        check(cache_m[3] == shadow[3], "R7 replica after repair", cache_m[3], shadow[3]);
        rd(3);   // R6 no error after repair

        // R4 three flips
        inj(1, 32'h8000_0101);
        rd(1);

        // R9 clean then corrupt -> lower memory; rewrite -> cache
        cln(2);
        inj(2, 32'h8000_0000);
        rd(2);
        wr(2, 32'h0BAD_F00D);
        inj(2, 32'h0000_0001);
        rd(2);

        // untouched line after reset comes from lower memory
        inj(12, 32'h0000_0070);
        rd(12);

        // R10 even flips undetected, R11 injection leaves dirty alone
        inj(7, 32'h0000_0003);
        rd(7);
        inj(7, 32'h0000_0010);
        rd(7);

        // R8 requests during busy are ignored
        resp_lat = 5;
        inj(9, 32'h0000_0001);
        rd_start(9);
        check(busy == 1'b1, "R8 busy during check", busy, 1);
        req_en = 1; req_write = 1; req_addr = 4; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        #1;
        check(recovering == 1'b1, "R7 recovering during fetch", recovering, 1);
        req_write = 0; req_addr = 5;
        @(negedge clk);
        req_en = 0;
        wait_idle();
        resp_lat = 0;
        check(cache_m[4] == '0, "R8 no replica write while busy", cache_m[4], 0);
        rd(4);
        rd(9);

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R3 all responses seen", sbq.size(), 0);
        finished = 1;
        summary();
        $finish;
    end
endmodule